// File: doc/BRIEF.md
# Command-Driven Two-Wire EEPROM Bus Master

This block lets a small processor run a two-wire serial bus, of the kind used by serial EEPROMs, one bus primitive at a time. The processor holds the byte to send, or picks up the byte received, in an 8-bit data register. It starts a bus action by writing a command code into the low nibble of an 8-bit control register. It then polls the same register for a busy flag, two acknowledge flags and an illegal-command flag.

Each action is built from quarter-phases of the serial clock, so software never toggles a pin. A quarter lasts `SCL_DIV/4` system clocks. With a system clock near 4.19 MHz this gives a serial clock near 100 kHz. Both bus lines are open-drain: the block only pulls a line low through an enable output and reads SDA back through an input. A line is high only when no device pulls it.

Top module: `twowire_cmd_master`

## Requirements
- R1: After reset, or when reset is asserted in the middle of an action, `scl_oe` and `sda_oe` are 0 (both lines released), `status` reads 8'h00 and `data_out` reads 8'h00.
- R2: Code 4'h9 (START) lowers SDA while SCL is high. It ends with both lines pulled low (`scl_oe`=1, `sda_oe`=1).
- R3: Code 4'h5 (STOP) raises SDA while SCL is high. It ends with both lines released.
- R4: Code 4'h3 (transmit) shifts the data register out MSB first and changes SDA only while SCL is low. On the ninth clock it releases SDA and samples it. Status bit 5 becomes 1 if SDA was low (acknowledge) and 0 if it was high.
- R5: Code 4'h2 samples eight bits MSB first into the data register and pulls SDA low on the ninth clock. Status bit 4 becomes 1.
- R6: Code 4'h6 samples eight bits into the data register and leaves SDA released on the ninth clock. Status bit 4 becomes 0.
- R7: `status` is {bit7 illegal, bit6 busy, bit5 ack received, bit4 ack sent, bits3:0 command}. While an action runs, bit 6 is 1 and bits 3:0 show its code. When it completes, bit 6 and bits 3:0 return to 0.
- R8: Writing an undefined code (any except 0, 2, 3, 5, 6, 9) sets bit 7 and causes no bus activity. A later write of any defined code clears bit 7. Code 4'h0 does nothing else.
- R9: Writes to the control or data register while bit 6 is 1 have no effect.
- R10: A byte bit lasts 4*(SCL_DIV/4) clocks, with SCL high for 2*(SCL_DIV/4) of them. Bit 6 stays 1 for 4*(SCL_DIV/4)+1 clocks for START and STOP, and 36*(SCL_DIV/4)+1 clocks for a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Write strobe for the control register (uses `wr_byte[3:0]`) |
| data_wr | input | 1 | Write strobe for the data register |
| wr_byte | input | 8 | Write data shared by both registers |
| status | output | 8 | Control/status register readback |
| data_out | output | 8 | Data register readback |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |
| sda_in | input | 1 | Sampled level of the data line |

## Verification
The assertions check on every cycle that SDA holds still while SCL is high during byte transfers, and that START and STOP leave the lines in their stated end states. They also check that the busy view and command nibble track the engine, that register writes while busy leave the registers untouched, and that the illegal flag only rises after an idle control write. Only the bench's scenarios can show the rest. These are the serialized bit order against a modelled slave, the sampled acknowledge and received bytes, the START/STOP edges seen on the wire, the exact busy durations and SCL high time, and recovery from a reset taken mid-byte.

// File: rtl/twm_pkg.sv
package twm_pkg;

    typedef enum logic [3:0] {
        CMD_NOP     = 4'd0,
        CMD_RX_ACK  = 4'd2,
        CMD_TX      = 4'd3,
        CMD_STOP    = 4'd5,
        CMD_RX_NACK = 4'd6,
        CMD_START   = 4'd9
    } cmd_code_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_START,
        OP_STOP,
        OP_TX,
        OP_RX_ACK,
        OP_RX_NACK
    } op_e;

    function automatic logic code_defined(input logic [3:0] c);
        case (c)
            CMD_NOP, CMD_RX_ACK, CMD_TX, CMD_STOP, CMD_RX_NACK, CMD_START: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic op_e code_to_op(input logic [3:0] c);
        case (c)
            CMD_START:   return OP_START;
            CMD_STOP:    return OP_STOP;
            CMD_TX:      return OP_TX;
            CMD_RX_ACK:  return OP_RX_ACK;
            CMD_RX_NACK: return OP_RX_NACK;
            default:     return OP_NONE;
        endcase
    endfunction

    function automatic logic op_is_byte(input op_e o);
        return (o == OP_TX) || (o == OP_RX_ACK) || (o == OP_RX_NACK);
    endfunction

endpackage

// File: rtl/twm_qtick.sv
module twm_qtick #(
    parameter int QTR = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(QTR + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } qt_t;

    qt_t qt_d, qt_q;

    assign tick = run && (qt_q.cnt == CW'(QTR - 1));

    always_comb begin
        qt_d = qt_q;
        if (!run || tick) qt_d.cnt = '0;
        else              qt_d.cnt = qt_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) qt_q <= '0;
        else        qt_q <= qt_d;
    end

    // R10: the quarter counter never passes its terminal value
    assert_qtr_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        qt_q.cnt < CW'(QTR));

endmodule

// File: rtl/twm_engine.sv
module twm_engine
    import twm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  op_e        go_op,
    input  logic [7:0] tx_byte,
    input  logic       sda_in,
    input  logic       tick,
    output logic       active,
    output logic       done,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic [7:0] rx_byte,
    output logic       slave_ack
);
    typedef struct packed {
        logic       active;
        logic       done;
        op_e        op;
        logic [1:0] ph;
        logic [3:0] bitn;
        logic [7:0] sh;
        logic       scl_oe;
        logic       sda_oe;
        logic       ack;
    } eng_t;

    eng_t eng_d, eng_q;
    logic enter;

    // {scl_oe, sda_oe} for each quarter of START and STOP
    function automatic logic [1:0] cond_lines(input op_e op, input logic [1:0] ph);
        if (op == OP_START) begin
            case (ph)
                2'd0:    return 2'b10;
                2'd1:    return 2'b00;
                2'd2:    return 2'b01;
                default: return 2'b11;
            endcase
        end else begin
            case (ph)
                2'd0:    return 2'b11;
                2'd1:    return 2'b01;
                default: return 2'b00;
            endcase
        end
    endfunction

    function automatic logic bit_low(input op_e op, input logic [3:0] b, input logic [7:0] sh);
        if (b == 4'd8) return (op == OP_RX_ACK);
        return (op == OP_TX) ? ~sh[7] : 1'b0;
    endfunction

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        enter      = 1'b0;
        if (!eng_q.active) begin
            if (go) begin
                eng_d.active = 1'b1;
                eng_d.op     = go_op;
                eng_d.ph     = 2'd0;
                eng_d.bitn   = 4'd0;
                eng_d.sh     = (go_op == OP_TX) ? tx_byte : 8'h00;
                enter        = 1'b1;
            end
        end else if (tick) begin
            enter = 1'b1;
            if (eng_q.ph == 2'd1 && op_is_byte(eng_q.op)) begin
                if (eng_q.bitn == 4'd8) begin
                    if (eng_q.op == OP_TX) eng_d.ack = ~sda_in;
                end else if (eng_q.op != OP_TX) begin
                    eng_d.sh = {eng_q.sh[6:0], sda_in};
                end
            end
            if (eng_q.ph == 2'd3) begin
                if (op_is_byte(eng_q.op) && eng_q.bitn != 4'd8) begin
                    eng_d.ph   = 2'd0;
                    eng_d.bitn = eng_q.bitn + 4'd1;
                    if (eng_q.op == OP_TX) eng_d.sh = {eng_q.sh[6:0], 1'b0};
                end else begin
                    eng_d.active = 1'b0;
                    eng_d.done   = 1'b1;
                    enter        = 1'b0;
                end
            end else begin
                eng_d.ph = eng_q.ph + 2'd1;
            end
        end
        if (enter) begin
            if (op_is_byte(eng_d.op)) begin
                eng_d.scl_oe = (eng_d.ph == 2'd0) || (eng_d.ph == 2'd3);
                if (eng_d.ph == 2'd0) eng_d.sda_oe = bit_low(eng_d.op, eng_d.bitn, eng_d.sh);
            end else begin
                {eng_d.scl_oe, eng_d.sda_oe} = cond_lines(eng_d.op, eng_d.ph);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign active    = eng_q.active;
    assign done      = eng_q.done;
    assign scl_oe    = eng_q.scl_oe;
    assign sda_oe    = eng_q.sda_oe;
    assign rx_byte   = eng_q.sh;
    assign slave_ack = eng_q.ack;

    // R4: data line holds while the clock line stays high inside a byte
    assert_sda_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.active && op_is_byte(eng_q.op) && !eng_q.scl_oe && !$past(eng_q.scl_oe))
        |-> $stable(eng_q.sda_oe));

    // R2: START leaves both lines held low
    assert_start_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.done && eng_q.op == OP_START) |-> (eng_q.scl_oe && eng_q.sda_oe));

    // R3: STOP leaves both lines released
    assert_stop_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.done && eng_q.op == OP_STOP) |-> (!eng_q.scl_oe && !eng_q.sda_oe));

endmodule

// File: rtl/twowire_cmd_master.sv
module twowire_cmd_master
    import twm_pkg::*;
#(
    parameter int SCL_DIV = 42
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic       data_wr,
    input  logic [7:0] wr_byte,
    output logic [7:0] status,
    output logic [7:0] data_out,
    output logic       scl_oe,
    output logic       sda_oe,
    input  logic       sda_in
);
    localparam int QTR = SCL_DIV / 4;

    typedef struct packed {
        logic [7:0] data;
        logic [3:0] cmd;
        logic       busy;
        logic       err;
        logic       rxack;
        logic       txack;
    } regs_t;

    regs_t regs_d, regs_q;

    logic       go;
    op_e        go_op;
    op_e        cur_op;
    logic       tick;
    logic       eng_active;
    logic       eng_done;
    logic [7:0] rx_byte;
    logic       slave_ack;

    assign go_op  = code_to_op(wr_byte[3:0]);
    assign cur_op = code_to_op(regs_q.cmd);

    always_comb begin
        regs_d = regs_q;
        go     = 1'b0;
        if (!regs_q.busy) begin
            if (data_wr) regs_d.data = wr_byte;
            if (ctrl_wr) begin
                if (!code_defined(wr_byte[3:0])) begin
                    regs_d.err = 1'b1;
                end else begin
                    regs_d.err = 1'b0;
                    if (wr_byte[3:0] != 4'd0) begin
                        regs_d.busy = 1'b1;
                        regs_d.cmd  = wr_byte[3:0];
                        go          = 1'b1;
                    end
                end
            end
        end else if (eng_done) begin
            regs_d.busy = 1'b0;
            regs_d.cmd  = 4'd0;
            case (cur_op)
                OP_TX:      regs_d.rxack = slave_ack;
                OP_RX_ACK:  begin regs_d.data = rx_byte; regs_d.txack = 1'b1; end
                OP_RX_NACK: begin regs_d.data = rx_byte; regs_d.txack = 1'b0; end
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    twm_qtick #(.QTR(QTR)) qtick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (eng_active),
        .tick  (tick)
    );

    twm_engine engine_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .go_op     (go_op),
        .tx_byte   (regs_q.data),
        .sda_in    (sda_in),
        .tick      (tick),
        .active    (eng_active),
        .done      (eng_done),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .rx_byte   (rx_byte),
        .slave_ack (slave_ack)
    );

    assign status   = {regs_q.err, regs_q.busy, regs_q.rxack, regs_q.txack, regs_q.cmd};
    assign data_out = regs_q.data;

    // R7: a running engine is always reported busy with its code visible
    assert_busy_view_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_active |-> (regs_q.busy && regs_q.cmd != 4'd0));

    // R9: registers do not move while busy, except at completion
    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.busy && !eng_done) |=> ($stable(regs_q.cmd) && $stable(regs_q.data)));

    // R8: the illegal flag only rises after an idle control write
    assert_err_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(regs_q.err) |-> $past(ctrl_wr && !regs_q.busy));

endmodule

// File: tb/twowire_cmd_master_tb.sv
module twowire_cmd_master_tb_top;
    localparam int SCL_DIV  = 42;
    localparam int QTR      = SCL_DIV / 4;
    localparam int BYTE_CYC = 36 * QTR + 1;
    localparam int COND_CYC = 4 * QTR + 1;
    localparam int NROWS    = 9;

    // {cmd4, data8, slave_byte8, slave_ack1, exp_status8, exp_data8, exp_wire8, start1, stop1}
    localparam logic [46:0] VEC [NROWS] = '{
        {4'h9, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0},
        {4'h3, 8'hA0, 8'h00, 1'b1, 8'h20, 8'hA0, 8'hA0, 1'b0, 1'b0},
        {4'h3, 8'h3C, 8'h00, 1'b0, 8'h00, 8'h3C, 8'h3C, 1'b0, 1'b0},
        {4'h2, 8'h00, 8'h5A, 1'b0, 8'h10, 8'h5A, 8'h5A, 1'b0, 1'b0},
        {4'h6, 8'h00, 8'hC3, 1'b0, 8'h00, 8'hC3, 8'hC3, 1'b0, 1'b0},
        {4'h3, 8'h81, 8'h00, 1'b1, 8'h20, 8'h81, 8'h81, 1'b0, 1'b0},
        {4'h5, 8'h81, 8'h00, 1'b0, 8'h20, 8'h81, 8'h00, 1'b0, 1'b1},
        {4'h7, 8'h81, 8'h00, 1'b0, 8'hA0, 8'h81, 8'h00, 1'b0, 1'b0},
        {4'h0, 8'h81, 8'h00, 1'b0, 8'h20, 8'h81, 8'h00, 1'b0, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ctrl_wr, data_wr;
    logic [7:0] wr_byte;
    logic [7:0] status, data_out;
    logic       scl_oe, sda_oe;
    logic       slave_pull;
    wire        scl_line = ~scl_oe;
    wire        sda_line = ~(sda_oe | slave_pull);

    int checks = 0;
    int errors = 0;

    twowire_cmd_master #(.SCL_DIV(SCL_DIV)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr),
        .data_wr  (data_wr),
        .wr_byte  (wr_byte),
        .status   (status),
        .data_out (data_out),
        .scl_oe   (scl_oe),
        .sda_oe   (sda_oe),
        .sda_in   (sda_line)
    );

    always #10 clk = ~clk;

    // slave model: counts SCL falls since launch, changes SDA only after a fall
    int         falls = 0;
    int         base  = 0;
    int         smode = 0;
    logic [7:0] sbyte = 8'h00;
    logic       sack  = 1'b0;
    always @(negedge scl_line) falls <= falls + 1;
    always_comb begin
        int k;
        k = falls - base;
        slave_pull = 1'b0;
        if (smode == 2 && k >= 0 && k < 8) slave_pull = ~sbyte[3'(7 - k)];
        if (smode == 1 && k == 8)           slave_pull = sack;
    end

    // wire monitor
    logic [8:0] wire_sh = '0;
    int  starts = 0, stops = 0;
    time t_rise = 0, hi_t = 0, per_t = 0;
    always @(posedge scl_line) begin
        wire_sh <= {wire_sh[7:0], sda_line};
        per_t   <= $time - t_rise;
        t_rise  <= $time;
    end
    always @(negedge scl_line) hi_t <= $time - t_rise;
    always @(negedge sda_line) if (scl_line === 1'b1) starts <= starts + 1;
    always @(posedge sda_line) if (scl_line === 1'b1) stops <= stops + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_data(input logic [7:0] v);
        data_wr = 1'b1; wr_byte = v;
        @(negedge clk);
        data_wr = 1'b0;
    endtask

    task automatic wr_ctrl(input logic [3:0] c);
        ctrl_wr = 1'b1; wr_byte = {4'h0, c};
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (status[6]) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic set_slave(input int mode, input logic [7:0] b, input logic a);
        smode = mode; sbyte = b; sack = a; base = falls;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n, s0, p0;
        rst_n = 1'b0; ctrl_wr = 1'b0; data_wr = 1'b0; wr_byte = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 status", status, 8'h00);
        chk("R1 data", data_out, 8'h00);
        chk("R1 lines", {scl_oe, sda_oe}, 2'b00);

        for (int i = 0; i < NROWS; i++) begin
            logic [3:0] c;
            logic       is_byte;
            string      rq;
            int         exp_n;
            c       = VEC[i][46:43];
            is_byte = (c == 4'h2) || (c == 4'h3) || (c == 4'h6);
            rq      = (c == 4'h9) ? "R2" : (c == 4'h5) ? "R3" : (c == 4'h3) ? "R4" :
                      (c == 4'h2) ? "R5" : (c == 4'h6) ? "R6" : "R8";
            exp_n   = is_byte ? BYTE_CYC : (c == 4'h9 || c == 4'h5) ? COND_CYC : 0;
            set_slave((c == 4'h3) ? 1 : (c == 4'h2 || c == 4'h6) ? 2 : 0, VEC[i][34:27], VEC[i][26]);
            wr_data(VEC[i][42:35]);
            s0 = starts; p0 = stops;
            wr_ctrl(c);
            if (exp_n != 0) chk("R7 busy view", {status[6], status[3:0]}, {1'b1, c});
            wait_idle(n);
            chk("R10 busy cycles", n, exp_n);
            chk({rq, " status"}, status, VEC[i][25:18]);
            chk({rq, " data"}, data_out, VEC[i][17:10]);
            chk({rq, " start edges"}, starts - s0, 32'(VEC[i][1]));
            chk({rq, " stop edges"}, stops - p0, 32'(VEC[i][0]));
            if (is_byte) chk({rq, " wire byte"}, wire_sh[8:1], VEC[i][9:2]);
        end

        // R2: START end state
        set_slave(0, 8'h00, 1'b0);
        wr_ctrl(4'h9);
        wait_idle(n);
        chk("R2 lines after start", {scl_oe, sda_oe}, 2'b11);

        // R9: writes during a transmit are ignored
        set_slave(1, 8'h00, 1'b0);
        wr_data(8'h55);
        p0 = stops;
        wr_ctrl(4'h3);
        chk("R7 nibble while busy", status[3:0], 4'h3);
        repeat (5) @(negedge clk);
        wr_ctrl(4'h5);
        wr_data(8'hFF);
        wait_idle(n);
        chk("R9 status", status, 8'h00);
        chk("R9 data kept", data_out, 8'h55);
        chk("R9 no stop", stops - p0, 0);
        chk("R4 wire byte", wire_sh[8:1], 8'h55);
        chk("R10 scl high time", 32'(hi_t), 32'(2 * QTR * 20));
        chk("R10 bit period", 32'(per_t), 32'(4 * QTR * 20));

        // R3: STOP end state
        set_slave(0, 8'h00, 1'b0);
        wr_ctrl(4'h5);
        wait_idle(n);
        chk("R3 lines after stop", {scl_oe, sda_oe}, 2'b00);

        // R1: reset in the middle of a receive
        set_slave(2, 8'hFF, 1'b0);
        wr_ctrl(4'h2);
        repeat (50) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid reset status", status, 8'h00);
        chk("R1 mid reset lines", {scl_oe, sda_oe}, 2'b00);
        rst_n = 1'b1;
        set_slave(0, 8'h00, 1'b0);
        @(negedge clk);
        chk("R1 mid reset data", data_out, 8'h00);

        // R8: another undefined code, then NOP clears the flag
        wr_ctrl(4'hF);
        chk("R8 illegal flag", status, 8'h80);
        chk("R8 no bus action", {scl_oe, sda_oe}, 2'b00);
        wr_ctrl(4'h0);
        chk("R8 nop clears", status, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule